// File: doc/BRIEF.md
# Tuner Control Register Bank

This block is the byte-wide configuration and status store for the digital control section of a television tuner. A host reaches it over a simple internal bus: a 4-bit address, 8-bit write data, and separate write and read strobes. Ten writable locations hold the synthesizer dividers, the oscillator selection, the charge-pump and filter-band choice, the signal-path enables and the tracking-filter capacitor codes. Each of these settings leaves the block as its own decoded output field.

Two further locations are read-only. One returns an entry of a small factory-calibration table, which is held inside the block as constant logic. The table can only be reached indirectly. Software first writes the wanted table index. It then raises a load bit from 0 to 1, which copies that entry into the readback location.

The second read-only location reports the lock indicator, which arrives as a 3-bit input. It also reports a power-on flag. The flag is set by reset and is cleared by the first read of the status location.

Top module: `tuner_cfg_regbank`

## Requirements
- R1: After synchronous reset the writable locations hold 0x00=0x12, 0x01=0x50, 0x02=0x40, 0x03=0x6D and 0x00 in 0x04..0x09. The calibration readback (0x0B) is 0x00 and the power-on flag is 1.
- R2: A read strobe latches the addressed byte into `bus_rdata`, which is valid from the clock edge that samples the strobe. With no strobe, `bus_rdata` holds its value. Locations 0x00..0x09 read back what was last written, with reserved bits forced to zero.
- R3: Reserved bits are stored as zero whatever is written. The kept-bit masks are: 0x00:0x7F, 0x02:0x7F, 0x04:0x7F, 0x05:0x0F, 0x06:0xF8, 0x08:0xBF, 0x09:0x0F. All other writable locations keep all 8 bits.
- R4: The fields decode as follows:
  - `pll_int_div` = {0x00[6:0], 0x01}; `ref_div` = 0x02[6:0].
  - From 0x03: `vco_sel` = [7:6], `vco_band` = [5:3], `lock_det_en` = [2], `vco_post_div` = [1:0].
  - From 0x04: `ovld_code` = [6:4], `pump_cur` = [3:2], `filt_band` = [1:0].
  - From 0x05: `rf_off` = [3], `ifamp_off` = [2], `rf_in_sel` = [1:0].
  - From 0x06: `mix_off` = [7:6], `if_off` = [5], `det_off` = [4], `synth_off` = [3].
  - `ser_cap` = 0x07; `par_cap` = 0x08[5:0].
- R5: Writes to 0x0A..0x0F change nothing. Reads of 0x0A and of 0x0D..0x0F return 0x00.
- R6: Writing 0x08 with bit 7 = 1 while the stored bit 7 is 0 copies the calibration entry indexed by 0x09[3:0] into 0x0B. No other write changes 0x0B. This includes rewriting bit 7 = 1 while it is already 1, and changing the index.
- R7: Calibration entry 0 is {OVLD_CODE, 5'b0}, which is 0xA0 by default. Entry k for k = 1..8 is (37*k + 11) mod 256. Indices 9..15 load 0x00.
- R8: The status byte at 0x0C is {power-on flag, `lock_ind`[2:0], 4'b0000}, with `lock_ind` sampled at the read strobe.
- R9: A read of 0x0C clears the power-on flag, and that same read still returns it as 1. Reads of other addresses do not clear it, and a reset sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| lock_ind | input | 3 | Lock / tuning-voltage indicator |
| pll_int_div | output | 15 | Synthesizer integer divider |
| ref_div | output | 7 | Reference divider |
| vco_sel | output | 2 | Oscillator select |
| vco_band | output | 3 | Oscillator sub-band |
| lock_det_en | output | 1 | Lock-detect enable |
| vco_post_div | output | 2 | Oscillator post-divider select |
| ovld_code | output | 3 | Overload-detector trim code |
| pump_cur | output | 2 | Charge-pump current select |
| filt_band | output | 2 | Tracking-filter band |
| rf_off | output | 1 | RF section off |
| ifamp_off | output | 1 | IF gain stage off |
| rf_in_sel | output | 2 | RF input select |
| mix_off | output | 2 | Mixer off code |
| if_off | output | 1 | IF section off |
| det_off | output | 1 | Power detector off |
| synth_off | output | 1 | Synthesizer off |
| ser_cap | output | 8 | Tracking-filter series capacitor code |
| par_cap | output | 6 | Tracking-filter parallel capacitor code |

## Verification
The hardest situation to reach is a calibration load whose outcome depends on history: the load bit must be seen at 0 before it is raised. The stimulus therefore walks every index 0..15 with an explicit clear-then-set of bit 7. It then retargets the index and rewrites bit 7 = 1 without clearing it, to prove that no second copy occurs. The power-on flag is likewise exercised across resets: it is read first at the status address, then again, and separately after reads of other addresses.

// File: rtl/tuner_cfg_pkg.sv
package tuner_cfg_pkg;

    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NUM_RW  = 10;
    localparam int CAL_DEP = 9;
    localparam int LOCK_W  = 3;

    localparam logic [ADDR_W-1:0] A_DIV_HI  = 4'h0;
    localparam logic [ADDR_W-1:0] A_DIV_LO  = 4'h1;
    localparam logic [ADDR_W-1:0] A_REF     = 4'h2;
    localparam logic [ADDR_W-1:0] A_OSC     = 4'h3;
    localparam logic [ADDR_W-1:0] A_TRIM    = 4'h4;
    localparam logic [ADDR_W-1:0] A_PATH    = 4'h5;
    localparam logic [ADDR_W-1:0] A_PWR     = 4'h6;
    localparam logic [ADDR_W-1:0] A_SCAP    = 4'h7;
    localparam logic [ADDR_W-1:0] A_PCAP    = 4'h8;
    localparam logic [ADDR_W-1:0] A_CALIDX  = 4'h9;
    localparam logic [ADDR_W-1:0] A_CALDATA = 4'hB;
    localparam logic [ADDR_W-1:0] A_STATUS  = 4'hC;

    localparam int LOAD_BIT = 7;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic [14:0] int_div;
        logic [6:0]  ref_div;
        logic [1:0]  osc_sel;
        logic [2:0]  osc_band;
        logic        lock_en;
        logic [1:0]  post_div;
    } synth_cfg_t;

    typedef struct packed {
        logic [2:0] ovld;
        logic [1:0] pump;
        logic [1:0] band;
        logic       rf_off;
        logic       ifamp_off;
        logic [1:0] in_sel;
        logic [1:0] mix_off;
        logic       if_off;
        logic       det_off;
        logic       syn_off;
        logic [7:0] scap;
        logic [5:0] pcap;
    } path_cfg_t;

    // Bits that a writable location keeps; the rest are reserved zeros.
    function automatic byte_t rw_mask(input int idx);
        case (idx)
            0, 2, 4: return 8'h7F;
            5, 9:    return 8'h0F;
            6:       return 8'hF8;
            8:       return 8'hBF;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic byte_t rw_default(input int idx);
        case (idx)
            0:       return 8'h12;
            1:       return 8'h50;
            2:       return 8'h40;
            3:       return 8'h6D;
            default: return 8'h00;
        endcase
    endfunction

    function automatic byte_t cal_entry(input int idx, input logic [2:0] od);
        if (idx == 0)
            return {od, 5'b0};
        else if (idx < CAL_DEP)
            return 8'((idx * 37 + 11) % 256);
        else
            return 8'h00;
    endfunction

    function automatic synth_cfg_t unpack_synth(input byte_t hi, input byte_t lo,
                                                input byte_t rf, input byte_t osc);
        synth_cfg_t s;
        s.int_div  = {hi[6:0], lo};
        s.ref_div  = rf[6:0];
        s.osc_sel  = osc[7:6];
        s.osc_band = osc[5:3];
        s.lock_en  = osc[2];
        s.post_div = osc[1:0];
        return s;
    endfunction

    function automatic path_cfg_t unpack_path(input byte_t trim, input byte_t path,
                                              input byte_t pwr, input byte_t scap,
                                              input byte_t pcap);
        path_cfg_t p;
        p.ovld      = trim[6:4];
        p.pump      = trim[3:2];
        p.band      = trim[1:0];
        p.rf_off    = path[3];
        p.ifamp_off = path[2];
        p.in_sel    = path[1:0];
        p.mix_off   = pwr[7:6];
        p.if_off    = pwr[5];
        p.det_off   = pwr[4];
        p.syn_off   = pwr[3];
        p.scap      = scap;
        p.pcap      = pcap[5:0];
        return p;
    endfunction

endpackage

// File: rtl/tcfg_reg_file.sv
module tcfg_reg_file
    import tuner_cfg_pkg::*;
#(
    parameter int N_REG = NUM_RW,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DW-1:0]             wr_data,
    output logic [N_REG-1:0][DW-1:0]  regs_q
);
    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        localparam logic [DW-1:0] KEEP = DW'(rw_mask(g));
        localparam logic [DW-1:0] INIT = DW'(rw_default(g));
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= INIT;
            else if (wr_en && wr_addr == AW'(g))
                regs_q[g] <= wr_data & KEEP;
        end
    end
endmodule

// File: rtl/tcfg_cal_rom.sv
module tcfg_cal_rom
    import tuner_cfg_pkg::*;
#(
    parameter int          DEPTH = CAL_DEP,
    parameter int          IW    = 4,
    parameter int          DW    = DATA_W,
    parameter logic [2:0]  OD    = 3'b101
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_req,
    input  logic [IW-1:0] idx,
    output logic [DW-1:0] readback_q
);
    logic [DW-1:0] tbl [DEPTH];
    logic [DW-1:0] sel;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        assign tbl[g] = DW'(cal_entry(g, OD));
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < DEPTH; i++)
            if (idx == IW'(i)) sel = tbl[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            readback_q <= '0;
        else if (load_req)
            readback_q <= sel;
    end
endmodule

// File: rtl/tcfg_status.sv
module tcfg_status
    import tuner_cfg_pkg::*;
#(
    parameter int LW = LOCK_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_clear,
    input  logic [LW-1:0] lock_ind,
    output logic          por_q,
    output logic [DW-1:0] status_byte
);
    always_ff @(posedge clk) begin
        if (rst)
            por_q <= 1'b1;
        else if (rd_clear)
            por_q <= 1'b0;
    end

    assign status_byte = {por_q, lock_ind, {(DW-1-LW){1'b0}}};
endmodule

// File: rtl/tuner_cfg_regbank.sv
module tuner_cfg_regbank
    import tuner_cfg_pkg::*;
#(
    parameter logic [2:0] OVLD_CODE = 3'b101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LOCK_W-1:0] lock_ind,
    output logic [14:0]       pll_int_div,
    output logic [6:0]        ref_div,
    output logic [1:0]        vco_sel,
    output logic [2:0]        vco_band,
    output logic              lock_det_en,
    output logic [1:0]        vco_post_div,
    output logic [2:0]        ovld_code,
    output logic [1:0]        pump_cur,
    output logic [1:0]        filt_band,
    output logic              rf_off,
    output logic              ifamp_off,
    output logic [1:0]        rf_in_sel,
    output logic [1:0]        mix_off,
    output logic              if_off,
    output logic              det_off,
    output logic              synth_off,
    output logic [7:0]        ser_cap,
    output logic [5:0]        par_cap
);
    logic [NUM_RW-1:0][DATA_W-1:0] regs;
    logic [DATA_W-1:0] cal_q, stat_b, rd_mux;
    logic              load_req, stat_rd, por;
    synth_cfg_t        syn;
    path_cfg_t         pth;

    tcfg_reg_file #(.N_REG(NUM_RW), .AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .regs_q(regs)
    );

    // Load only on a 0-to-1 change of the stored load bit.
    assign load_req = bus_wr && bus_addr == A_PCAP && bus_wdata[LOAD_BIT]
                      && !regs[int'(A_PCAP)][LOAD_BIT];

    tcfg_cal_rom #(.DEPTH(CAL_DEP), .IW(4), .DW(DATA_W), .OD(OVLD_CODE)) u_rom (
        .clk(clk), .rst(rst), .load_req(load_req),
        .idx(regs[int'(A_CALIDX)][3:0]), .readback_q(cal_q)
    );

    assign stat_rd = bus_rd && bus_addr == A_STATUS;

    tcfg_status #(.LW(LOCK_W), .DW(DATA_W)) u_stat (
        .clk(clk), .rst(rst), .rd_clear(stat_rd), .lock_ind(lock_ind),
        .por_q(por), .status_byte(stat_b)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_RW; i++)
            if (bus_addr == ADDR_W'(i)) rd_mux = regs[i];
        if (bus_addr == A_CALDATA) rd_mux = cal_q;
        if (bus_addr == A_STATUS)  rd_mux = stat_b;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    assign syn = unpack_synth(regs[int'(A_DIV_HI)], regs[int'(A_DIV_LO)],
                              regs[int'(A_REF)], regs[int'(A_OSC)]);
    assign pth = unpack_path(regs[int'(A_TRIM)], regs[int'(A_PATH)],
                             regs[int'(A_PWR)], regs[int'(A_SCAP)], regs[int'(A_PCAP)]);

    assign pll_int_div  = syn.int_div;
    assign ref_div      = syn.ref_div;
    assign vco_sel      = syn.osc_sel;
    assign vco_band     = syn.osc_band;
    assign lock_det_en  = syn.lock_en;
    assign vco_post_div = syn.post_div;
    assign ovld_code    = pth.ovld;
    assign pump_cur     = pth.pump;
    assign filt_band    = pth.band;
    assign rf_off       = pth.rf_off;
    assign ifamp_off    = pth.ifamp_off;
    assign rf_in_sel    = pth.in_sel;
    assign mix_off      = pth.mix_off;
    assign if_off       = pth.if_off;
    assign det_off      = pth.det_off;
    assign synth_off    = pth.syn_off;
    assign ser_cap      = pth.scap;
    assign par_cap      = pth.pcap;

    logic unused_por;
    assign unused_por = por;
endmodule

// File: rtl/tuner_cfg_regbank_chk.sv
module tuner_cfg_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_rdata,
    input logic [14:0] pll_int_div,
    input logic [6:0]  ref_div,
    input logic [7:0]  ser_cap,
    input logic [5:0]  par_cap,
    input logic [7:0]  cal_q,
    input logic        por_q
);
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    assert_rsvd_top_bit_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr == 4'h0 |=> bus_rdata[7] == 1'b0);

    assert_refdiv_field_R4: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr == 4'h2 |=> ref_div == $past(bus_wdata[6:0]));

    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_addr >= 4'hA |=> $stable(pll_int_div) && $stable(ser_cap)
                                     && $stable(par_cap) && $stable(cal_q));

    assert_cal_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 4'h8 && bus_wdata[7]) |=> $stable(cal_q));

    assert_status_low_R8: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr == 4'hC |=> bus_rdata[3:0] == 4'h0);

    assert_por_clear_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr == 4'hC |=> !por_q);

    assert_por_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !por_q |=> !por_q);
endmodule

bind tuner_cfg_regbank tuner_cfg_regbank_chk chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pll_int_div(pll_int_div), .ref_div(ref_div), .ser_cap(ser_cap),
    .par_cap(par_cap), .cal_q(cal_q), .por_q(por)
);

// File: tb/tuner_cfg_regbank_tb_top.sv
module tuner_cfg_regbank_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] lock_ind = 3'b011;
    logic [14:0] pll_int_div;
    logic [6:0] ref_div;
    logic [1:0] vco_sel, vco_post_div, pump_cur, filt_band, rf_in_sel, mix_off;
    logic [2:0] vco_band, ovld_code;
    logic lock_det_en, rf_off, ifamp_off, if_off, det_off, synth_off;
    logic [7:0] ser_cap;
    logic [5:0] par_cap;

    int n_vec = 0, n_bad = 0, cycles = 0;

    always #2.5 clk = ~clk;

    tuner_cfg_regbank dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .lock_ind(lock_ind),
        .pll_int_div(pll_int_div), .ref_div(ref_div), .vco_sel(vco_sel),
        .vco_band(vco_band), .lock_det_en(lock_det_en), .vco_post_div(vco_post_div),
        .ovld_code(ovld_code), .pump_cur(pump_cur), .filt_band(filt_band),
        .rf_off(rf_off), .ifamp_off(ifamp_off), .rf_in_sel(rf_in_sel),
        .mix_off(mix_off), .if_off(if_off), .det_off(det_off), .synth_off(synth_off),
        .ser_cap(ser_cap), .par_cap(par_cap)
    );

    function automatic logic [7:0] keep_of(int a);
        case (a)
            0, 2, 4: return 8'h7F;
            5, 9:    return 8'h0F;
            6:       return 8'hF8;
            8:       return 8'hBF;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] init_of(int a);
        case (a)
            0: return 8'h12;
            1: return 8'h50;
            2: return 8'h40;
            3: return 8'h6D;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] cal_of(int k);
        if (k == 0) return 8'hA0;
        if (k <= 8) return 8'((37 * k + 11) % 256);
        return 8'h00;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic t_reset_R1();
        logic [7:0] d;
        do_reset();
        check("R1 int_div", 32'(pll_int_div), 32'd4688);
        check("R1 ref_div", 32'(ref_div), 32'd64);
        check("R1 osc", {vco_sel, vco_band, lock_det_en, vco_post_div}, 32'h6D);
        rd(4'hB, d); check("R1 cal readback", 32'(d), 32'h00);
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), d); check($sformatf("R1 reg %0d", a), 32'(d), 32'(init_of(a)));
        end
    endtask

    task automatic t_rw_R2_R3();
        logic [7:0] d;
        logic [7:0] pats [3] = '{8'hFF, 8'h00, 8'hA5};
        do_reset();
        foreach (pats[p]) begin
            for (int a = 0; a < 10; a++) wr(4'(a), pats[p] ^ 8'(a));
            for (int a = 0; a < 10; a++) begin
                rd(4'(a), d);
                check($sformatf("R2/R3 reg %0d", a), 32'(d), 32'((pats[p] ^ 8'(a)) & keep_of(a)));
            end
        end
        rd(4'h1, d);
        repeat (3) @(negedge clk);
        check("R2 rdata hold", 32'(bus_rdata), 32'(d));
    endtask

    task automatic t_fields_R4();
        do_reset();
        wr(4'h0, 8'hD5); wr(4'h1, 8'h3C); wr(4'h2, 8'h9B); wr(4'h3, 8'h92);
        wr(4'h4, 8'h6B); wr(4'h5, 8'h0E); wr(4'h6, 8'hA8); wr(4'h7, 8'h5A); wr(4'h8, 8'h2D);
        check("R4 int_div", 32'(pll_int_div), 32'h553C);
        check("R4 ref_div", 32'(ref_div), 32'h1B);
        check("R4 vco_sel", 32'(vco_sel), 32'h2);
        check("R4 vco_band", 32'(vco_band), 32'h2);
        check("R4 lock_det_en", 32'(lock_det_en), 32'h0);
        check("R4 post_div", 32'(vco_post_div), 32'h2);
        check("R4 ovld/pump/band", {ovld_code, pump_cur, filt_band}, 32'h6B);
        check("R4 path", {rf_off, ifamp_off, rf_in_sel}, 32'hE);
        check("R4 pwr", {mix_off, if_off, det_off, synth_off}, 32'h15);
        check("R4 ser_cap", 32'(ser_cap), 32'h5A);
        check("R4 par_cap", 32'(par_cap), 32'h2D);
    endtask

    task automatic t_ignored_R5();
        logic [7:0] d;
        do_reset();
        wr(4'h9, 8'h03); wr(4'h8, 8'h80);
        for (int a = 10; a < 16; a++) wr(4'(a), 8'hFF);
        check("R5 int_div kept", 32'(pll_int_div), 32'd4688);
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), d);
            check($sformatf("R5 reg %0d kept", a), 32'(d),
                  32'(a == 9 ? 8'h03 : (a == 8 ? 8'h80 : init_of(a))));
        end
        rd(4'hB, d); check("R5 cal kept", 32'(d), 32'(cal_of(3)));
        foreach (d[i]) begin end
        rd(4'hA, d); check("R5 read 0x0A", 32'(d), 32'h00);
        for (int a = 13; a < 16; a++) begin
            rd(4'(a), d); check($sformatf("R5 read 0x%0h", a), 32'(d), 32'h00);
        end
    endtask

    task automatic t_cal_R6_R7();
        logic [7:0] d;
        do_reset();
        for (int k = 0; k < 16; k++) begin
            wr(4'h9, 8'(k)); wr(4'h8, 8'h00); wr(4'h8, 8'h80);
            rd(4'hB, d); check($sformatf("R7 entry %0d", k), 32'(d), 32'(cal_of(k)));
        end
        wr(4'h9, 8'h05); wr(4'h8, 8'h00); wr(4'h8, 8'h80);
        wr(4'h9, 8'h02);
        rd(4'hB, d); check("R6 index change no load", 32'(d), 32'(cal_of(5)));
        wr(4'h8, 8'h81);
        rd(4'hB, d); check("R6 bit already set no load", 32'(d), 32'(cal_of(5)));
        wr(4'h8, 8'h01); wr(4'h8, 8'h80);
        rd(4'hB, d); check("R6 re-arm loads", 32'(d), 32'(cal_of(2)));
    endtask

    task automatic t_status_R8_R9();
        logic [7:0] d;
        do_reset();
        lock_ind = 3'b011;
        rd(4'hC, d); check("R9 first read flag set", 32'(d), 32'hB0);
        lock_ind = 3'b110;
        rd(4'hC, d); check("R8/R9 second read", 32'(d), 32'h60);
        do_reset();
        rd(4'h0, d); rd(4'hB, d);
        lock_ind = 3'b000;
        rd(4'hC, d); check("R9 other reads keep flag", 32'(d), 32'h80);
        lock_ind = 3'b111;
        rd(4'hC, d); check("R8 lock bits", 32'(d), 32'h70);
        do_reset();
        rd(4'hC, d); check("R9 reset sets flag", 32'(d), 32'hF0);
    endtask

    initial begin
        t_reset_R1();
        t_rw_R2_R3();
        t_fields_R4();
        t_ignored_R5();
        t_cal_R6_R7();
        t_status_R8_R9();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule